// File: doc/BRIEF.md
# Cascaded 16-bit Square-Wave Timer

This block pairs two 8-bit timer slices into a single 16-bit counter that drives a square wave. The lower slice supplies the count rate: its clock-select field picks a power-of-two division of the system clock. The resulting one-cycle strobe advances the joined counter. Each slice keeps one byte of the 16-bit compare value N. When the count reaches N, several things happen on the same strobe: the counter returns to zero, the output flip-flop inverts, and a one-cycle interrupt pulse is raised. The output period is therefore 2·t·(N+1) system-clock cycles, where t = 2^sel.

Software programs the block through a byte-wide write port. Each slice has three registers, selected by a slice bit and a field index. Counting runs only while both slices have their run and join bits set. The intended start order is the upper slice first, then the lower slice. While the timer is stopped, two level bits can force the output flip-flop high or low. A toggle-enable bit and a pin-enable bit complete the control set.

Top module: `sqw_cascade_timer`

## Requirements
- R1: After reset every register is zero, `tmr_out` is low and `tmr_irq` is low.
- R2: The 16-bit compare value N takes its low byte from the lower slice's compare register (address 2) and its high byte from the upper slice's compare register (address 6). Any N from 0000h to FFFFh is accepted. With clock select 0, the output first inverts N+1 cycles after the start write, and the counter clears on each match.
- R3: Each match inverts the output and raises `tmr_irq` for one cycle at the same clock edge. Matches repeat every N+1 count strobes.
- R4: The lower slice's clock-select register (address 1, bits 2:0 = sel) divides the count rate by 2^sel, for sel from 0 to 7. The match interval is (N+1)·2^sel cycles.
- R5: The upper slice's clock-select register (address 5) has no effect on the count rate.
- R6: Counting happens only while both control registers (lower at address 0, upper at address 4) have bit 0 (run) and bit 1 (join) set. Otherwise the output does not change and no interrupt is raised.
- R7: Clearing a run or join bit stops counting. It also clears the counter and the prescaler and leaves the output level unchanged, so a restart takes a full interval.
- R8: While stopped, lower control bit 4 (level-high) = 1 with bit 5 (level-low) = 0 forces the output flip-flop high. Bit 4 = 0 with bit 5 = 1 forces it low.
- R9: While stopped, bits 4 and 5 both 1 or both 0 leave the output flip-flop unchanged.
- R10: With lower control bit 2 (toggle enable) clear, a match still pulses `tmr_irq` but does not invert the output.
- R11: With lower control bit 3 (pin enable) clear, `tmr_out` is low whatever the flip-flop holds. Setting the bit shows the held level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Bit 2 selects the slice (0 lower, 1 upper); bits 1:0 select the field (0 control, 1 clock select, 2 compare) |
| wr_data | input | 8 | Write data |
| tmr_out | output | 1 | Square-wave output, gated by pin enable |
| tmr_irq | output | 1 | One-cycle pulse on each match |

## Verification
A wrong count or a wrong prescaler state shows as a misplaced edge on `tmr_out` or `tmr_irq`. This becomes visible at the first match after start, within (N+1)·2^sel cycles, so the bench measures every interval exactly from the start write. A counter or prescaler that is not cleared on stop shows up on restart, where the first interval comes out short. A corrupted flip-flop level shows within one cycle through the preset bits, once the pin enable is set.

// File: rtl/sqw_timer_pkg.sv
// Package: field indices and control-bit positions shared by the timer modules.
// Assumes: each slice exposes three byte registers, addressed {slice, field}.
package sqw_timer_pkg;
    typedef enum logic [1:0] {
        FLD_CTRL   = 2'd0,
        FLD_CLKSEL = 2'd1,
        FLD_CMP    = 2'd2
    } sqw_field_e;

    localparam int CB_RUN     = 0;  // slice run enable
    localparam int CB_JOIN    = 1;  // join slices into one counter
    localparam int CB_TOGEN   = 2;  // allow output inversion on match (lower slice)
    localparam int CB_PINEN   = 3;  // drive output pin (lower slice)
    localparam int CB_LVL_HI  = 4;  // preset level high while stopped (lower slice)
    localparam int CB_LVL_LO  = 5;  // preset level low while stopped (lower slice)
endpackage

// File: rtl/sqw_timer_regs.sv
// Register bank: per slice a control, a clock-select and a compare byte.
// Assumes: wr_addr = {slice index, 2-bit field}; unused fields are ignored.
module sqw_timer_regs
    import sqw_timer_pkg::*;
#(
    parameter int SLICE_W = 8,
    parameter int NSLICE  = 2,
    parameter int SEL_W   = 3,
    parameter int ADDR_W  = $clog2(NSLICE) + 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [ADDR_W-1:0]                 wr_addr,
    input  logic [SLICE_W-1:0]                wr_data,
    output logic [NSLICE-1:0][SLICE_W-1:0]    ctrl_q,
    output logic [NSLICE-1:0][SEL_W-1:0]      clksel_q,
    output logic [NSLICE-1:0][SLICE_W-1:0]    cmp_q
);
    localparam int IDX_W = ADDR_W - 2;

    logic [1:0] fld;
    assign fld = wr_addr[1:0];

    for (genvar s = 0; s < NSLICE; s++) begin : g_slice
        logic sel_hit;
        assign sel_hit = wr_en && (wr_addr[ADDR_W-1:2] == IDX_W'(s));

        // Capture writes addressed to this slice.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ctrl_q[s]   <= '0;
                clksel_q[s] <= '0;
                cmp_q[s]    <= '0;
            end else if (sel_hit) begin
                case (fld)
                    FLD_CTRL:   ctrl_q[s]   <= wr_data;
                    FLD_CLKSEL: clksel_q[s] <= wr_data[SEL_W-1:0];
                    FLD_CMP:    cmp_q[s]    <= wr_data;
                    default:    ;
                endcase
            end
        end
    end
endmodule

// File: rtl/sqw_timer_prescaler.sv
// Prescaler: emits a one-cycle strobe every 2^sel cycles while running.
// Assumes: cleared while stopped; counter is never used as a clock.
module sqw_timer_prescaler #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int PW = (1 << SEL_W) - 1;

    logic [PW-1:0] pre_q;
    logic [PW-1:0] mask;

    assign mask = (PW'(1) << sel) - PW'(1);
    assign tick = run && ((pre_q & mask) == mask);

    // Free-run the divider while counting, hold at zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)   pre_q <= '0;
        else if (run) pre_q <= pre_q + PW'(1);
        else          pre_q <= '0;
    end
endmodule

// File: rtl/sqw_timer_counter.sv
// Joined counter: NSLICE byte slices chained by carry, compared with the
// per-slice compare bytes; clears on a full match.
// Assumes: slice 0 holds the least significant byte.
module sqw_timer_counter #(
    parameter int SLICE_W = 8,
    parameter int NSLICE  = 2,
    parameter int CNT_W   = SLICE_W * NSLICE
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           run,
    input  logic                           tick,
    input  logic [NSLICE-1:0][SLICE_W-1:0] cmp,
    output logic                           hit,
    output logic [CNT_W-1:0]               cnt
);
    logic [NSLICE:0]   carry;
    logic [NSLICE-1:0] eq;
    logic              match;

    assign carry[0] = tick;
    assign match    = &eq;
    assign hit      = tick && match;

    for (genvar s = 0; s < NSLICE; s++) begin : g_byte
        logic [SLICE_W-1:0] byte_q;
        assign eq[s]        = (byte_q == cmp[s]);
        assign carry[s+1]   = carry[s] && (byte_q == {SLICE_W{1'b1}});
        assign cnt[s*SLICE_W +: SLICE_W] = byte_q;

        // Advance on carry-in, clear on match or when stopped.
        always_ff @(posedge clk) begin
            if (!rst_n)        byte_q <= '0;
            else if (!run)     byte_q <= '0;
            else if (hit)      byte_q <= '0;
            else if (carry[s]) byte_q <= byte_q + SLICE_W'(1);
        end
    end
endmodule

// File: rtl/sqw_cascade_timer.sv
// Top: joined square-wave timer. Lower slice supplies clock select, output
// controls and presets; the upper slice only contributes run/join and a byte.
// Assumes: synchronous active-low reset; single clock domain.
module sqw_cascade_timer
    import sqw_timer_pkg::*;
#(
    parameter int SLICE_W = 8,
    parameter int NSLICE  = 2,
    parameter int SEL_W   = 3,
    parameter int ADDR_W  = $clog2(NSLICE) + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [SLICE_W-1:0] wr_data,
    output logic               tmr_out,
    output logic               tmr_irq
);
    localparam int CNT_W = SLICE_W * NSLICE;

    logic [NSLICE-1:0][SLICE_W-1:0] ctrl_q;
    logic [NSLICE-1:0][SEL_W-1:0]   clksel_q;
    logic [NSLICE-1:0][SLICE_W-1:0] cmp_q;
    logic [NSLICE-1:0]              slice_go;
    logic                           run;
    logic                           tick;
    logic                           hit;
    logic [CNT_W-1:0]               cnt;
    logic                           ff_q;
    logic                           irq_q;
    logic                           tog_en, pin_en, lvl_hi, lvl_lo;

    sqw_timer_regs #(
        .SLICE_W(SLICE_W), .NSLICE(NSLICE), .SEL_W(SEL_W), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ctrl_q(ctrl_q), .clksel_q(clksel_q), .cmp_q(cmp_q)
    );

    for (genvar s = 0; s < NSLICE; s++) begin : g_go
        assign slice_go[s] = ctrl_q[s][CB_RUN] && ctrl_q[s][CB_JOIN];
    end
    assign run    = &slice_go;
    assign tog_en = ctrl_q[0][CB_TOGEN];
    assign pin_en = ctrl_q[0][CB_PINEN];
    assign lvl_hi = ctrl_q[0][CB_LVL_HI];
    assign lvl_lo = ctrl_q[0][CB_LVL_LO];

    sqw_timer_prescaler #(.SEL_W(SEL_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(run), .sel(clksel_q[0]), .tick(tick)
    );

    sqw_timer_counter #(.SLICE_W(SLICE_W), .NSLICE(NSLICE)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .cmp(cmp_q),
        .hit(hit), .cnt(cnt)
    );

    // Output flip-flop: invert on match while running, preset while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ff_q  <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            irq_q <= hit;
            if (run) begin
                if (hit && tog_en) ff_q <= ~ff_q;
            end else if (lvl_hi && !lvl_lo) begin
                ff_q <= 1'b1;
            end else if (lvl_lo && !lvl_hi) begin
                ff_q <= 1'b0;
            end
        end
    end

    assign tmr_out = pin_en && ff_q;
    assign tmr_irq = irq_q;
endmodule

// File: rtl/sqw_cascade_timer_chk.sv
// Checker: temporal properties of the joined timer, bound to the top.
// Assumes: observes internal run state, flip-flop, counter and control bits.
module sqw_cascade_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             ff_q,
    input logic             irq,
    input logic [CNT_W-1:0] cnt,
    input logic             pin_en,
    input logic             lvl_hi,
    input logic             lvl_lo,
    input logic             tmr_out
);
    AST_IRQ_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (cnt == '0)); // R2
    AST_FLIP_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run) && (ff_q != $past(ff_q))) |-> irq); // R3
    AST_IRQ_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(run)); // R6
    AST_IDLE_CNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(run) |-> (cnt == '0)); // R7
    AST_PRESET_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!run && lvl_hi && !lvl_lo) |-> ff_q); // R8
    AST_PRESET_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!run && !lvl_hi && lvl_lo) |-> !ff_q); // R8
    AST_PRESET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!run && (lvl_hi == lvl_lo)) |-> (ff_q == $past(ff_q))); // R9
    AST_PIN_LOW_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_en |-> !tmr_out); // R11
endmodule

bind sqw_cascade_timer sqw_cascade_timer_chk #(.CNT_W(SLICE_W * NSLICE)) u_chk (
    .clk(clk), .rst_n(rst_n), .run(run), .ff_q(ff_q), .irq(tmr_irq),
    .cnt(cnt), .pin_en(pin_en), .lvl_hi(lvl_hi), .lvl_lo(lvl_lo),
    .tmr_out(tmr_out)
);

// File: tb/sqw_cascade_timer_bench.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each measuring edge timing at ports.
module sqw_cascade_timer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       tmr_out, tmr_irq;
    int         n_cmp = 0;
    int         n_bad = 0;

    // control byte values (lower/upper)
    localparam logic [7:0] C_GO_LO  = 8'h0F; // run|join|toggle|pin
    localparam logic [7:0] C_GO_HI  = 8'h03; // run|join
    localparam logic [7:0] C_PIN    = 8'h08;
    localparam logic [7:0] C_LOW    = 8'h28; // pin|level-low
    localparam logic [7:0] C_HIGH   = 8'h18; // pin|level-high

    always #2.5 clk = ~clk;

    sqw_cascade_timer u_sqw_cascade_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .tmr_out(tmr_out), .tmr_irq(tmr_irq)
    );

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_flip(input int maxc, output int n);
        logic start;
        start = tmr_out;
        n = -1;
        for (int i = 1; i <= maxc; i++) begin
            @(negedge clk);
            if (tmr_out != start) begin n = i; break; end
        end
    endtask

    task automatic set_up(input int nval, input int sel);
        wr(3'd0, C_LOW);          // stop, force low
        @(negedge clk);
        wr(3'd2, nval[7:0]);
        wr(3'd6, nval[15:8]);
        wr(3'd1, sel[7:0]);
        wr(3'd4, C_GO_HI);
    endtask

    task automatic t_reset();
        check("R1 out after reset", int'(tmr_out), 0);
        check("R1 irq after reset", int'(tmr_irq), 0);
    endtask

    task automatic t_basic();
        int n;
        set_up(16'h0102, 0);
        wr(3'd0, C_GO_LO);
        wait_flip(400, n);
        check("R2 first interval N=0102h", n, 259);
        check("R3 irq with flip", int'(tmr_irq), 1);
        @(negedge clk);
        check("R3 irq one cycle", int'(tmr_irq), 0);
        wait_flip(400, n);
        check("R3 second interval", n, 258);
        check("R3 out low again", int'(tmr_out), 0);
    endtask

    task automatic t_carry_and_zero();
        int n;
        set_up(16'h0100, 0);
        wr(3'd0, C_GO_LO);
        wait_flip(400, n);
        check("R2 byte carry N=0100h", n, 257);
        set_up(0, 1);
        wr(3'd0, C_GO_LO);
        wait_flip(20, n);
        check("R2 N=0 sel=1 first", n, 2);
        wait_flip(20, n);
        check("R2 N=0 sel=1 next", n, 2);
    endtask

    task automatic t_prescale();
        int n;
        set_up(4, 3);
        wr(3'd5, 8'h07);         // upper clock select must be ignored
        wr(3'd0, C_GO_LO);
        wait_flip(200, n);
        check("R4 sel=3 N=4 interval", n, 40);
        check("R5 upper select ignored", n, 40);
        set_up(1, 7);
        wr(3'd5, 8'h00);
        wr(3'd0, C_GO_LO);
        wait_flip(600, n);
        check("R4 sel=7 N=1 interval", n, 256);
    endtask

    task automatic t_need_both();
        int n;
        set_up(3, 0);
        wr(3'd4, 8'h02);          // upper joined but not running
        wr(3'd0, C_GO_LO);
        wait_flip(40, n);
        check("R6 upper run clear: no flip", n, -1);
        check("R6 upper run clear: no irq", int'(tmr_irq), 0);
        wr(3'd4, 8'h01);          // running but not joined
        wait_flip(40, n);
        check("R6 join clear: no flip", n, -1);
        wr(3'd4, C_GO_HI);
        wait_flip(40, n);
        check("R6 start after upper set", n, 4);
    endtask

    task automatic t_restart();
        int n;
        set_up(9, 0);
        wr(3'd0, C_GO_LO);
        repeat (4) @(negedge clk);
        wr(3'd0, C_PIN);          // stop without preset
        wait_flip(20, n);
        check("R7 stopped: no flip", n, -1);
        check("R7 level held", int'(tmr_out), 0);
        wr(3'd0, C_GO_LO);
        wait_flip(40, n);
        check("R7 restart full interval", n, 10);
    endtask

    task automatic t_preset();
        wr(3'd0, C_HIGH);
        @(negedge clk);
        check("R8 preset high", int'(tmr_out), 1);
        wr(3'd0, 8'h38);          // both levels
        @(negedge clk);
        check("R9 both set holds high", int'(tmr_out), 1);
        wr(3'd0, C_LOW);
        @(negedge clk);
        check("R8 preset low", int'(tmr_out), 0);
        wr(3'd0, C_PIN);          // neither level
        repeat (2) @(negedge clk);
        check("R9 neither holds low", int'(tmr_out), 0);
    endtask

    task automatic t_togen();
        int pulses = 0;
        int flips = 0;
        logic last;
        set_up(2, 0);
        wr(3'd0, 8'h0B);          // run|join|pin, no toggle
        last = tmr_out;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (tmr_irq) pulses++;
            if (tmr_out != last) flips++;
            last = tmr_out;
        end
        check("R10 irq count without toggle", pulses, 10);
        check("R10 no output flip", flips, 0);
    endtask

    task automatic t_pin();
        wr(3'd0, 8'h10);          // level-high, pin disabled
        repeat (2) @(negedge clk);
        check("R11 pin disabled low", int'(tmr_out), 0);
        wr(3'd0, C_PIN);
        check("R11 pin enabled shows high", int'(tmr_out), 1);
    endtask

    initial begin : wdog
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_carry_and_zero();
        t_prescale();
        t_need_both();
        t_restart();
        t_preset();
        t_togen();
        t_pin();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule